// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Generator

This block produces eight independent pulse-width-modulated outputs. Software programs them over a simple memory-mapped bus with a synchronous write and a combinational read. Each channel has three registers: a period, a duty and a control word. The control word holds a clock-divider code and an output inversion bit. Counting is paced by a `tick` input, which is an enable pulse at 1 MHz. A per-channel divider turns that pulse into counter steps.

Duty and control writes land only in shadow copies. A write to the period register, whatever value it carries, arms a commit. The armed shadow values replace the running ones only at the boundary of the period in progress. Each output therefore moves from one full setting to the next with no mixed period in between.

Writing a zero period lets the running period finish and then parks the output low. If a channel is idle, a non-zero period write starts it on the next clock.

Top module: `shadow_pwm`

## Requirements
- R1: Register map with 12-bit byte addresses and word access (address bits [1:0] must be 0). Channel c uses period at 0x400+4c, duty at 0x420+4c and control at 0x440+4c. Reads return the last written value. Period and duty keep the low 16 bits. Control keeps bit 5 and bits [1:0] and reads other bits as 0. Any other address reads 0 and ignores writes.
- R2: After reset all registers read 0, every channel is idle and every output is low.
- R3: When a channel is idle, a period write with a non-zero value starts it at the next clock edge. The counter and the divider both start from 0.
- R4: While a channel runs, its counter steps from 0 to period−1 and wraps. The output is active while count < duty. Duty 0 is never active, and duty ≥ period is always active.
- R5: Control bits [1:0] set the number of ticks per counter step: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R6: Control bit 5 set to 1 inverts the output of a running channel.
- R7: Writes to duty or control change only the shadow copy. Without a later period write they never alter the output.
- R8: On a running channel, a period write arms a commit. The commit loads all three shadow values at the edge that would wrap the counter, and it does so even when the written period equals the current one.
- R9: An armed zero period lets the running period complete. From then on the output stays low regardless of the inversion bit.
- R10: A zero-period write followed by a non-zero period write, both before the running period ends, still waits for that boundary and then runs the new setting.
- R11: Channels are independent: activity on one channel leaves another channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz enable pulse that paces counting |
| busAddr | input | 12 | Byte address for read and write |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pwmOut | output | 8 | One PWM output per channel |

## Verification
The hardest case to reach is a commit armed partway through a period, especially when the zero-period stop is overturned by a non-zero write before the running period ends. The stimulus first starts a channel from idle at a known edge, so its counter phase is known from then on. It then places the duty, control and period writes on chosen cycles inside the running period. Before issuing those writes, the scoreboard queues the full per-cycle waveform: the old setting up to the boundary and the new setting after it. Any early load, late load or mixed period therefore shows up on a specific sample.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  // stored control: bit 2 = inversion, bits 1:0 = divider code
  localparam int CTRL_W = 3;
  localparam int CTRL_POL_BIT = 5;
  localparam logic [6:0] BANK_PERIOD = 7'h20;
  localparam logic [6:0] BANK_DUTY   = 7'h21;
  localparam logic [6:0] BANK_CTRL   = 7'h22;

  typedef struct packed {
    logic load;  // copy shadow into the active set, restart counting
    logic halt;  // the loaded period is zero: go idle
  } chStrobe_t;
endpackage

// File: rtl/shpwm_regs_ctrl.sv
module shpwm_regs_ctrl
  import shpwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWrEn,
  input  logic [DATA_W-1:0]                busWrData,
  output logic [DATA_W-1:0]                busRdData,
  input  logic [NUM_CH-1:0]                running,
  input  logic [NUM_CH-1:0]                periodEnd,
  output logic [NUM_CH-1:0][CNT_W-1:0]     shPeriod,
  output logic [NUM_CH-1:0][CNT_W-1:0]     shDuty,
  output logic [NUM_CH-1:0][CTRL_W-1:0]    shCtrl,
  output chStrobe_t [NUM_CH-1:0]           strobes
);
  logic [6:0] bankSel;
  logic [2:0] chSel;
  logic       wordOk;
  logic       unusedWr;

  assign bankSel  = busAddr[11:5];
  assign chSel    = busAddr[4:2];
  assign wordOk   = (busAddr[1:0] == 2'b00);
  assign unusedWr = ^busWrData;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    localparam logic [2:0] CH_IDX = 3'(ch);
    logic             hit, wrPer, wrDuty, wrCtrl;
    logic             pend, commit;
    logic [CNT_W-1:0] perReg, dutyReg;
    logic [CTRL_W-1:0] ctrlReg;

    assign hit    = busWrEn && wordOk && (chSel == CH_IDX);
    assign wrPer  = hit && (bankSel == BANK_PERIOD);
    assign wrDuty = hit && (bankSel == BANK_DUTY);
    assign wrCtrl = hit && (bankSel == BANK_CTRL);

    // an armed commit fires when idle or on the wrap edge
    assign commit = pend && (periodEnd[ch] || !running[ch]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        perReg  <= '0;
        dutyReg <= '0;
        ctrlReg <= '0;
        pend    <= 1'b0;
      end else begin
        if (wrPer)  perReg  <= busWrData[CNT_W-1:0];
        if (wrDuty) dutyReg <= busWrData[CNT_W-1:0];
        if (wrCtrl) ctrlReg <= {busWrData[CTRL_POL_BIT], busWrData[1:0]};
        if (wrPer)       pend <= 1'b1;
        else if (commit) pend <= 1'b0;
      end
    end

    assign shPeriod[ch]     = perReg;
    assign shDuty[ch]       = dutyReg;
    assign shCtrl[ch]       = ctrlReg;
    assign strobes[ch].load = commit;
    assign strobes[ch].halt = commit && (perReg == '0);
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wordOk && (chSel == 3'(i))) begin
        case (bankSel)
          BANK_PERIOD: busRdData = DATA_W'(shPeriod[i]);
          BANK_DUTY:   busRdData = DATA_W'(shDuty[i]);
          BANK_CTRL: begin
            busRdData[CTRL_POL_BIT] = shCtrl[i][2];
            busRdData[1:0]          = shCtrl[i][1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/shpwm_channel.sv
module shpwm_channel
  import shpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  chStrobe_t         strobe,
  input  logic [CNT_W-1:0]  ldPeriod,
  input  logic [CNT_W-1:0]  ldDuty,
  input  logic [CTRL_W-1:0] ldCtrl,
  output logic              pwmBit,
  output logic              running,
  output logic              periodEnd
);
  logic [CNT_W-1:0] actPeriod, actDuty, count;
  logic [1:0]       actDiv;
  logic             actPol, runFlag, step;
  logic [PRE_W-1:0] preCnt, divLast;

  always_comb begin
    case (actDiv)
      2'd0:    divLast = PRE_W'(0);
      2'd1:    divLast = PRE_W'(1);
      2'd2:    divLast = PRE_W'(3);
      default: divLast = PRE_W'(7);
    endcase
  end

  assign step      = runFlag && tick && (preCnt == divLast);
  assign periodEnd = step && (count == actPeriod - CNT_W'(1));
  assign running   = runFlag;
  assign pwmBit    = runFlag && ((count < actDuty) ^ actPol);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPeriod <= '0;
      actDuty   <= '0;
      actDiv    <= '0;
      actPol    <= 1'b0;
      count     <= '0;
      preCnt    <= '0;
      runFlag   <= 1'b0;
    end else if (strobe.load) begin
      actPeriod <= ldPeriod;
      actDuty   <= ldDuty;
      actDiv    <= ldCtrl[1:0];
      actPol    <= ldCtrl[2];
      count     <= '0;
      preCnt    <= '0;
      runFlag   <= !strobe.halt;
    end else if (runFlag && tick) begin
      if (step) begin
        preCnt <= '0;
        count  <= periodEnd ? '0 : count + CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/shpwm_datapath.sv
module shpwm_datapath
  import shpwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  chStrobe_t [NUM_CH-1:0]        strobes,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shPeriod,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  shDuty,
  input  logic [NUM_CH-1:0][CTRL_W-1:0] shCtrl,
  output logic [NUM_CH-1:0]             pwmOut,
  output logic [NUM_CH-1:0]             running,
  output logic [NUM_CH-1:0]             periodEnd
);
  localparam int PRE_W = 3;  // largest divide is 8

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    shpwm_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chan_i (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tick),
      .strobe   (strobes[ch]),
      .ldPeriod (shPeriod[ch]),
      .ldDuty   (shDuty[ch]),
      .ldCtrl   (shCtrl[ch]),
      .pwmBit   (pwmOut[ch]),
      .running  (running[ch]),
      .periodEnd(periodEnd[ch])
    );
  end
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shpwm_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chStrobe_t [NUM_CH-1:0]          strobes;
  logic [NUM_CH-1:0][CNT_W-1:0]    shPeriod, shDuty;
  logic [NUM_CH-1:0][CTRL_W-1:0]   shCtrl;
  logic [NUM_CH-1:0]               runningVec, periodEndVec, commitVec;

  shpwm_regs_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .running  (runningVec),
    .periodEnd(periodEndVec),
    .shPeriod (shPeriod),
    .shDuty   (shDuty),
    .shCtrl   (shCtrl),
    .strobes  (strobes)
  );

  shpwm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .strobes  (strobes),
    .shPeriod (shPeriod),
    .shDuty   (shDuty),
    .shCtrl   (shCtrl),
    .pwmOut   (pwmOut),
    .running  (runningVec),
    .periodEnd(periodEndVec)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCommit
    assign commitVec[ch] = strobes[ch].load;
  end
endmodule

// File: rtl/shpwm_checker.sv
module shpwm_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] running,
  input logic [NUM_CH-1:0] periodEnd,
  input logic [NUM_CH-1:0] commit
);
  // R9: an idle channel drives low whatever its inversion bit
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~running) == '0);

  // R8: a running channel only takes new settings on its wrap edge
  assert_commit_boundary_R8: assert property (@(posedge clk) disable iff (!rstN)
    (commit & running & ~periodEnd) == '0);

  // R3: a channel only starts after a commit strobe
  assert_start_after_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running & ~$past(running) & ~$past(commit)) == '0);

  // R9: a channel only stops at the end of a full period
  assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (~running & $past(running) & ~$past(periodEnd)) == '0);
endmodule

bind shadow_pwm shpwm_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .pwmOut   (pwmOut),
  .running  (runningVec),
  .periodEnd(periodEndVec),
  .commit   (commitVec)
);

// File: tb/shadow_pwm_tb_top.sv
`timescale 1ns/1ps
module shadow_pwm_tb_top;
  localparam int NCH = 8;

  typedef struct {
    logic [NCH-1:0] mask;
    logic [NCH-1:0] value;
    string          tag;
  } expItem_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           tick = 1'b1;
  logic [11:0]    busAddr = '0;
  logic           busWrEn = 1'b0;
  logic [31:0]    busWrData = '0;
  logic [31:0]    busRdData;
  logic [NCH-1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  shadow_pwm dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] perA(input int c);
    return 12'(12'h400 + 4 * c);
  endfunction
  function automatic logic [11:0] dutyA(input int c);
    return 12'(12'h420 + 4 * c);
  endfunction
  function automatic logic [11:0] ctrlA(input int c);
    return 12'(12'h440 + 4 * c);
  endfunction

  // expected level from R4/R5/R6: j = clocks since start, div = ticks per step
  function automatic bit lvl(input int j, input int p, input int d,
                             input int div, input bit pol);
    return (((j / div) % p) < d) ^ pol;
  endfunction

  // called at a falling edge; the write lands on the next rising edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [31:0] exp,
                           input string tag);
    busAddr = a;
    #1;
    check(busRdData == exp, tag, busRdData, exp);
  endtask

  task automatic push(input logic [NCH-1:0] mask, input logic [NCH-1:0] value,
                      input string tag);
    expItem_t it;
    it.mask = mask; it.value = value; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushCh(input int c, input bit v, input string tag);
    push(NCH'(1) << c, NCH'(v) << c, tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) begin
      @(posedge clk);
      #6;
    end
  endtask

  task automatic startCheck(input int c, input logic [31:0] ctl, input int d,
                            input int p, input int div, input int n,
                            input string tag);
    @(negedge clk);
    busWrite(ctrlA(c), ctl);
    busWrite(dutyA(c), 32'(d));
    busWrite(perA(c), 32'(p));
    for (int j = 0; j < n; j++) pushCh(c, lvl(j, p, d, div, ctl[5]), tag);
    drain();
  endtask

  // scoreboard monitor: one expected item per clock, sampled mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check((pwmOut & it.mask) == it.value, it.tag,
              32'(pwmOut & it.mask), 32'(it.value));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pwmOut == '0, "R2 outputs low in reset", 32'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck(perA(0), 0, "R2 period reset");
    readCheck(dutyA(7), 0, "R2 duty reset");
    readCheck(ctrlA(3), 0, "R2 ctrl reset");
    check(pwmOut == '0, "R2 outputs low after reset", 32'(pwmOut), 0);

    // R7: duty/control writes on an idle channel do not start it
    @(negedge clk);
    busWrite(ctrlA(0), 32'h0);
    busWrite(dutyA(0), 32'd3);
    @(negedge clk);
    check(pwmOut[0] == 1'b0, "R7 idle after duty write", 32'(pwmOut[0]), 0);

    // R3/R4: start from idle, period 5, duty 3
    busWrite(perA(0), 32'd5);
    for (int j = 0; j < 10; j++) pushCh(0, lvl(j, 5, 3, 1, 0), "R3 R4 start ch0");
    drain();

    // R7/R8: mid-period shadow writes, commit at the wrap edge
    for (int k = 10; k < 15; k++) pushCh(0, lvl(k, 5, 3, 1, 0), "R7 old setting kept");
    for (int j = 0; j < 8; j++) pushCh(0, lvl(j, 4, 1, 1, 1), "R8 R6 new setting");
    @(negedge clk);
    busWrite(dutyA(0), 32'd1);
    busWrite(ctrlA(0), 32'h20);
    busWrite(perA(0), 32'd4);
    drain();

    // R9: zero period finishes the period then holds low despite inversion
    for (int j = 8; j < 12; j++) pushCh(0, lvl(j, 4, 1, 1, 1), "R9 period completes");
    for (int j = 12; j < 16; j++) pushCh(0, 1'b0, "R9 held low");
    @(negedge clk);
    busWrite(perA(0), 32'd0);
    drain();

    // R10/R11: stop then restart before the boundary on ch1; ch0 stays idle
    @(negedge clk);
    busWrite(ctrlA(1), 32'h0);
    busWrite(dutyA(1), 32'd2);
    busWrite(perA(1), 32'd6);
    for (int j = 0; j < 6; j++)
      push(NCH'(3), NCH'(lvl(j, 6, 2, 1, 0)) << 1, "R10 R11 old period runs");
    for (int m = 0; m < 6; m++)
      push(NCH'(3), NCH'(lvl(m, 3, 1, 1, 0)) << 1, "R10 R11 restart at boundary");
    busWrite(perA(1), 32'd0);
    busWrite(perA(1), 32'd3);
    busWrite(dutyA(1), 32'd1);
    drain();

    // R7/R8: duty alone has no effect; same-value period write commits it
    for (int n = 6; n < 12; n++) pushCh(1, lvl(n, 3, 1, 1, 0), "R7 duty alone ignored");
    for (int n = 12; n < 18; n++) pushCh(1, lvl(n, 3, 2, 1, 0), "R8 same period commits");
    @(negedge clk);
    busWrite(dutyA(1), 32'd2);
    repeat (3) @(negedge clk);
    busWrite(perA(1), 32'd3);
    drain();

    // R5: divider codes
    startCheck(2, 32'h2, 1, 2, 4, 16, "R5 divide by 4");
    startCheck(3, 32'h3, 1, 2, 8, 24, "R5 divide by 8");
    startCheck(4, 32'h1, 1, 3, 2, 12, "R5 divide by 2");
    // R4/R6 corners
    startCheck(5, 32'h0, 7, 3, 1, 6, "R4 duty above period");
    startCheck(6, 32'h20, 0, 3, 1, 6, "R4 R6 duty zero inverted");

    // R1: register map and readback
    @(negedge clk);
    busWrite(ctrlA(7), 32'hFFFF_FFFF);
    busWrite(dutyA(7), 32'h0001_2345);
    busWrite(12'h460, 32'h1234_5678);
    readCheck(ctrlA(7), 32'h23, "R1 ctrl readback mask");
    readCheck(dutyA(7), 32'h2345, "R1 duty readback width");
    readCheck(12'h460, 32'h0, "R1 unmapped reads zero");
    readCheck(perA(0), 32'h0, "R1 period last written");
    readCheck(dutyA(1), 32'd2, "R1 duty ch1");
    readCheck(perA(6), 32'd3, "R1 period ch6");
    check(pwmOut[7] == 1'b0, "R7 ch7 shadow only", 32'(pwmOut[7]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule